// File: doc/BRIEF.md
# Near Control Transfer Sequencer

This block works out the next instruction pointer for near, same-segment control transfers. It handles four kinds of transfer: the one-way jump, the call, the return from a procedure and the return from an interrupt. A jump or a call may be relative or absolute. A relative transfer adds a signed displacement of one or four bytes to the address of the following instruction. An absolute transfer takes a 32-bit target unchanged, from either a register or a memory operand.

Calls and returns share one small on-chip stack. The stack is a local word RAM addressed by the block's own stack pointer, and the block touches one word of it per clock cycle. It grows downward in 4-byte steps. A return can also discard parameter bytes, given by an immediate, once it has popped the saved pointer. A return from an interrupt pops the instruction pointer and then a flags word, which it restores.

A request is a single cycle with `req_valid` high, and the block accepts it only while idle. `busy` stays high for the whole sequence, and `done` pulses once at the end.

Top module: `ctrl_xfer_seq`

## Requirements
- R1: For a relative operation (`req_op` 0 = relative jump, 2 = relative call), the target is `next_ip` plus the displacement sign-extended to 32 bits, using `disp[7:0]` when `disp_wide` = 0 and all 32 bits of `disp` when `disp_wide` = 1.
- R2: For an absolute operation (`req_op` 1 = absolute jump, 3 = absolute call), the target is `abs_target`, copied unchanged into `ip_out`.
- R3: A jump leaves `sp_out` unchanged, writes nothing to the stack and sets `ip_out` to the target.
- R4: A call stores `next_ip` in the stack word at `sp_out - 4` and then sets `ip_out` to the target.
- R5: A return (`req_op` 4) loads `ip_out` from the word at `sp_out`, then adds 4 plus the zero-extended 16-bit `ret_imm` to `sp_out`.
- R6: A return from interrupt (`req_op` 5) pops `ip_out` first and the flags word second, then restores `flags_out` from it; in total `sp_out` grows by 8.
- R7: Every push first lowers the stack pointer by 4. Every pop raises it by 4 after the read.
- R8: `done` is high for exactly one cycle, and that cycle directly follows the last stack access. Counted from the accepting edge, `done` goes high after 1 cycle for a jump, 2 for a call or return, and 3 for a return from interrupt.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. A request that arrives while `busy` is high is ignored.
- R10: After reset, `ip_out` = 0, `sp_out` = `SP_RESET` (64 by default), `flags_out` = 0, and `busy` and `done` are both low.
- R11: Any accepted operation other than a return from interrupt loads `flags_out` from `flags_in`.
- R12: Codes 6 and 7 of `req_op` are ignored. They leave `busy` low and leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Operation request, one cycle |
| req_op | input | 3 | Operation code |
| disp | input | 32 | Signed displacement |
| disp_wide | input | 1 | 1 = four-byte displacement, 0 = one byte |
| abs_target | input | 32 | Absolute target from register or memory |
| ret_imm | input | 16 | Bytes released after a return |
| flags_in | input | 32 | Current flags word |
| next_ip | input | 32 | Address of the following instruction |
| ip_out | output | 32 | Instruction pointer |
| sp_out | output | 32 | Stack pointer |
| flags_out | output | 32 | Flags word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that every pop reads a word that an earlier push wrote. They also assume that the stack never moves further than its RAM depth away from the reset pointer, because addresses wrap silently and no check catches them. The stimulus nests calls no deeper than four, and each return or return from interrupt is issued only over words that calls have already pushed. Requests repeated while `busy` is high, and the reserved codes, are applied on purpose, because their effect is defined: they are ignored.

// File: rtl/ctrl_xfer_pkg.sv
package ctrl_xfer_pkg;

  localparam int XLEN       = 32;
  localparam int WORD_BYTES = 4;

  typedef enum logic [2:0] {
    OP_JMP_REL  = 3'd0,
    OP_JMP_ABS  = 3'd1,
    OP_CALL_REL = 3'd2,
    OP_CALL_ABS = 3'd3,
    OP_RET      = 3'd4,
    OP_IRET     = 3'd5
  } xfer_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP_IP,
    ST_POP_FL,
    ST_DONE
  } seq_st_e;

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic logic op_is_call(input logic [2:0] op);
    return (op == OP_CALL_REL) || (op == OP_CALL_ABS);
  endfunction

  function automatic logic op_is_jump(input logic [2:0] op);
    return (op == OP_JMP_REL) || (op == OP_JMP_ABS);
  endfunction

  function automatic logic op_is_rel(input logic [2:0] op);
    return (op == OP_JMP_REL) || (op == OP_CALL_REL);
  endfunction

  function automatic logic [XLEN-1:0] sext_disp(input logic [XLEN-1:0] d,
                                                input logic wide);
    return wide ? d : {{(XLEN-8){d[7]}}, d[7:0]};
  endfunction

  function automatic logic [XLEN-1:0] pop_adjust(input logic [XLEN-1:0] sp,
                                                 input logic [15:0] imm);
    return sp + XLEN'(WORD_BYTES) + {{(XLEN-16){1'b0}}, imm};
  endfunction

endpackage

// File: rtl/ctrl_xfer_target.sv
module ctrl_xfer_target
  import ctrl_xfer_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] disp,
  input  logic            disp_wide,
  input  logic [XLEN-1:0] abs_target,
  input  logic [XLEN-1:0] next_ip,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] rel_sum;

  always_comb begin
    rel_sum = next_ip + sext_disp(disp, disp_wide);
    target  = op_is_rel(op) ? rel_sum : abs_target;
  end
endmodule

// File: rtl/ctrl_xfer_stack.sv
module ctrl_xfer_stack #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ctrl_xfer_seq.sv
module ctrl_xfer_seq
  import ctrl_xfer_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter logic [31:0] SP_RESET = 32'd64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_op,
  input  logic [31:0] disp,
  input  logic        disp_wide,
  input  logic [31:0] abs_target,
  input  logic [15:0] ret_imm,
  input  logic [31:0] flags_in,
  input  logic [31:0] next_ip,
  output logic [31:0] ip_out,
  output logic [31:0] sp_out,
  output logic [31:0] flags_out,
  output logic        busy,
  output logic        done
);
  seq_st_e         state;
  logic [2:0]      op_q;
  logic [XLEN-1:0] target_q, ret_q, ip_q, sp_q, flags_q;
  logic [15:0]     imm_q;
  logic [XLEN-1:0] target, sp_dec, rdata;
  logic [AW-1:0]   ram_addr;

  // named events for the checker
  logic req_accept, accept_jmp, push_fire, pop_fire, pop_last, is_call_q;

  ctrl_xfer_target u_target (
    .op(req_op), .disp(disp), .disp_wide(disp_wide),
    .abs_target(abs_target), .next_ip(next_ip), .target(target)
  );

  assign sp_dec   = sp_q - XLEN'(WORD_BYTES);
  assign ram_addr = (state == ST_PUSH) ? sp_dec[AW+1:2] : sp_q[AW+1:2];

  ctrl_xfer_stack #(.DEPTH(DEPTH), .WIDTH(XLEN)) u_stack (
    .clk(clk), .wr_en(push_fire), .addr(ram_addr), .wdata(ret_q), .rdata(rdata)
  );

  assign req_accept = req_valid && (state == ST_IDLE) && op_known(req_op);
  assign accept_jmp = req_accept && op_is_jump(req_op);
  assign push_fire  = (state == ST_PUSH);
  assign pop_fire   = (state == ST_POP_IP) || (state == ST_POP_FL);
  assign pop_last   = (state == ST_POP_FL) ||
                      ((state == ST_POP_IP) && (op_q == OP_RET));
  assign is_call_q  = op_is_call(op_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= 3'd0;
      target_q <= '0;
      ret_q    <= '0;
      imm_q    <= '0;
      ip_q     <= '0;
      sp_q     <= SP_RESET;
      flags_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_accept) begin
          op_q     <= req_op;
          target_q <= target;
          ret_q    <= next_ip;
          imm_q    <= ret_imm;
          if (req_op != OP_IRET) flags_q <= flags_in;
          if (op_is_jump(req_op)) begin
            ip_q  <= target;
            state <= ST_DONE;
          end else if (op_is_call(req_op)) begin
            state <= ST_PUSH;
          end else begin
            state <= ST_POP_IP;
          end
        end
        ST_PUSH: begin
          sp_q  <= sp_dec;
          ip_q  <= target_q;
          state <= ST_DONE;
        end
        ST_POP_IP: begin
          ip_q <= rdata;
          if (op_q == OP_RET) begin
            sp_q  <= pop_adjust(sp_q, imm_q);
            state <= ST_DONE;
          end else begin
            sp_q  <= pop_adjust(sp_q, 16'd0);
            state <= ST_POP_FL;
          end
        end
        ST_POP_FL: begin
          flags_q <= rdata;
          sp_q    <= pop_adjust(sp_q, 16'd0);
          state   <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ip_out    = ip_q;
  assign sp_out    = sp_q;
  assign flags_out = flags_q;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
endmodule

// File: rtl/ctrl_xfer_chk.sv
module ctrl_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        req_accept,
  input logic        accept_jmp,
  input logic        push_fire,
  input logic        pop_fire,
  input logic        pop_last,
  input logic        is_call_q,
  input logic [31:0] sp_out
);
  AST_PUSH_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> is_call_q); // R4
  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp_out == $past(sp_out) - 32'd4); // R7
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_fire && pop_fire)); // R7
  AST_JMP_KEEPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    accept_jmp |=> $stable(sp_out) && done); // R3
  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire || pop_last) |=> done); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_COVERS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_accept); // R9
endmodule

bind ctrl_xfer_seq ctrl_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .req_accept(req_accept), .accept_jmp(accept_jmp), .push_fire(push_fire),
  .pop_fire(pop_fire), .pop_last(pop_last), .is_call_q(is_call_q),
  .sp_out(sp_out)
);

// File: tb/ctrl_xfer_seq_bench.sv
`timescale 1ns/1ps
module ctrl_xfer_seq_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] disp = '0, abs_target = '0, flags_in = '0, next_ip = '0;
  logic        disp_wide = 1'b0;
  logic [15:0] ret_imm = '0;
  logic [31:0] ip_out, sp_out, flags_out;
  logic        busy, done;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  ctrl_xfer_seq #(.DEPTH(DEPTH), .SP_RESET(32'd64)) u_ctrl_xfer_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .disp(disp), .disp_wide(disp_wide), .abs_target(abs_target),
    .ret_imm(ret_imm), .flags_in(flags_in), .next_ip(next_ip),
    .ip_out(ip_out), .sp_out(sp_out), .flags_out(flags_out),
    .busy(busy), .done(done)
  );

  // behavioural reference model
  longint unsigned ref_ip, ref_sp, ref_flags;
  longint unsigned ref_mem [int];
  int ref_cnt;

  function automatic longint unsigned widen(input logic [31:0] v);
    return {32'b0, v};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_ip = 0; ref_sp = 64; ref_flags = 0; ref_cnt = 0;
    end else if (ref_cnt > 0) begin
      ref_cnt = ref_cnt - 1;               // R9: requests here are ignored
    end else if (req_valid && req_op < 3'd6) begin  // R12
      longint unsigned tgt;
      if (req_op == 3'd0 || req_op == 3'd2) begin   // R1
        longint signed d;
        d = disp_wide ? longint'($signed(disp)) : longint'($signed(disp[7:0]));
        tgt = (widen(next_ip) + longint'(d)) & 64'hFFFF_FFFF;
      end else tgt = widen(abs_target);             // R2
      if (req_op != 3'd5) ref_flags = widen(flags_in); // R11
      case (req_op)
        3'd0, 3'd1: begin ref_ip = tgt; ref_cnt = 1; end            // R3
        3'd2, 3'd3: begin                                           // R4 R7
          ref_sp = (ref_sp - 4) & 64'hFFFF_FFFF;
          ref_mem[int'((ref_sp >> 2) % DEPTH)] = widen(next_ip);
          ref_ip = tgt; ref_cnt = 2;
        end
        3'd4: begin                                                 // R5
          ref_ip = ref_mem[int'((ref_sp >> 2) % DEPTH)];
          ref_sp = (ref_sp + 4 + ret_imm) & 64'hFFFF_FFFF;
          ref_cnt = 2;
        end
        default: begin                                              // R6
          ref_ip = ref_mem[int'((ref_sp >> 2) % DEPTH)];
          ref_sp = ref_sp + 4;
          ref_flags = ref_mem[int'((ref_sp >> 2) % DEPTH)];
          ref_sp = ref_sp + 4;
          ref_cnt = 3;
        end
      endcase
    end
  end

  task automatic check(input string tag, input longint unsigned act,
                       input longint unsigned exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8 R9 busy", widen({31'b0, busy}), (ref_cnt > 0) ? 1 : 0);
      check("R8 done", widen({31'b0, done}), (ref_cnt == 1) ? 1 : 0);
      if (ref_cnt <= 1) begin
        check("R1 R2 R3 R4 R5 R6 ip", widen(ip_out), ref_ip);
        check("R3 R4 R5 R6 R7 sp", widen(sp_out), ref_sp);
        check("R6 R11 flags", widen(flags_out), ref_flags);
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [31:0] d,
                       input logic w, input logic [31:0] abs_t,
                       input logic [15:0] imm, input logic [31:0] fl,
                       input logic [31:0] nip, input int hold);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; disp = d; disp_wide = w;
    abs_target = abs_t; ret_imm = imm; flags_in = fl; next_ip = nip;
    repeat (hold) @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ip", widen(ip_out), 0);
    check("R10 sp", widen(sp_out), 64);
    check("R10 flags", widen(flags_out), 0);
    check("R10 busy/done", widen({30'b0, busy, done}), 0);
    rst_n = 1'b1;
    issue(3'd0, 32'h0000_00F0, 1'b0, 32'h0, 16'd0, 32'h11, 32'h1000, 1); // R1 negative byte
    issue(3'd0, 32'h0000_0040, 1'b0, 32'h0, 16'd0, 32'h12, 32'h1000, 1); // R1 positive byte
    issue(3'd0, 32'hFFFF_FF00, 1'b1, 32'h0, 16'd0, 32'h13, 32'h2000, 1); // R1 wide
    issue(3'd1, 32'h0, 1'b0, 32'hDEAD_BEE0, 16'd0, 32'h14, 32'h3000, 1); // R2 R3
    issue(3'd2, 32'h0000_0010, 1'b0, 32'h0, 16'd0, 32'h15, 32'h4000, 1); // R4 R7
    issue(3'd3, 32'h0, 1'b0, 32'h0000_8000, 16'd0, 32'h16, 32'h5000, 1); // R2 R4
    issue(3'd4, 32'h0, 1'b0, 32'h0, 16'd0, 32'h17, 32'h0, 1);            // R5
    issue(3'd4, 32'h0, 1'b0, 32'h0, 16'd0, 32'h18, 32'h0, 1);            // R5
    issue(3'd2, 32'h0000_0100, 1'b1, 32'h0, 16'd0, 32'h19, 32'h6000, 1); // R4
    issue(3'd3, 32'h0, 1'b0, 32'h0000_9000, 16'd0, 32'h1A, 32'h7000, 1); // R4
    issue(3'd4, 32'h0, 1'b0, 32'h0, 16'd4, 32'h1B, 32'h0, 1);            // R5 imm
    issue(3'd3, 32'h0, 1'b0, 32'h0000_A000, 16'd0, 32'h1C, 32'h0000_0ACE, 1); // saved flags
    issue(3'd3, 32'h0, 1'b0, 32'h0000_B000, 16'd0, 32'h1D, 32'h0000_B0B0, 1);
    issue(3'd5, 32'h0, 1'b0, 32'h0, 16'd0, 32'h1E, 32'h0, 1);            // R6
    issue(3'd2, 32'h0000_0008, 1'b0, 32'h0, 16'd0, 32'h1F, 32'hC000, 3); // R9 held while busy
    issue(3'd4, 32'h0, 1'b0, 32'h0, 16'd0, 32'h20, 32'h0, 2);            // R9
    issue(3'd6, 32'h0, 1'b0, 32'hFFFF_0000, 16'd0, 32'h21, 32'h0, 1);    // R12
    issue(3'd7, 32'h0, 1'b0, 32'hFFFF_0000, 16'd0, 32'h22, 32'h0, 1);    // R12
    issue(3'd1, 32'h0, 1'b0, 32'h1234_5678, 16'd0, 32'h23, 32'h0, 1);    // R2 R11
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule